// File: doc/BRIEF.md
# OSD Display Window Timing Generator

This block sits in the pixel-clock domain of a monitor controller and turns the horizontal and vertical flyback inputs into the timing that an on-screen-display overlay needs. Each flyback input passes through a two-stage synchronizer. It is then normalized to an active-high level according to a programmable polarity bit. The asserting edge of each normalized signal becomes the reference point for a dot counter and a line counter.

From those counters the block raises a window-active flag. The flag starts a programmable number of lines below the vertical reference, in steps of 4 lines, and a programmable number of dots after the horizontal reference, in steps of 6 dots. The flag ends at the dots-per-line limit chosen by a resolution field. Inside the window the block reports the dot column. It also reports a glyph row index from 0 to 17 and a character-row count. The glyph row index stretches each 18-row character cell over a programmable height of 18 to 63 lines, so the overlay keeps the same physical size whatever the resolution. Downstream logic uses these outputs to address a character memory and shift out pixels.

Top module: `osd_window_gen`

## Requirements
- R1: Polarity bit 1 treats a flyback input as active high and bit 0 treats it as active low. For the same active-pulse timing, both settings give identical outputs. The horizontal polarity bit is bit 15 of control word 0 and the vertical polarity bit is bit 14. Polarity bits apply as soon as they are written.
- R2: A leading (asserting) flyback edge sampled at clock edge k restarts the counters at clock edge k+2. After that the dot position increases by one per clock. A vertical edge restarts the line count at 0 and wins over a coincident horizontal edge. Every other horizontal edge adds one line.
- R3: The dot counter stops at the dots-per-line value and holds there until the next horizontal edge. The resolution field in bits 9:8 of control word 0 selects 640 (00), 800 (01), 1024 (10) or 1280 (11) dots per line. The window is inactive from dot position dots-per-line onward.
- R4: The window is horizontally active while hStart*6 <= dot position < dots-per-line, where hStart is bits 7:0 of control word 1. The dot column output is (dot position - hStart*6) when the window is active and 0 otherwise.
- R5: The window is vertically active on lines with index >= vStart*4, where vStart is bits 15:8 of control word 1 and line 0 starts at the vertical edge.
- R6: The cell height H is bits 5:0 of control word 0. Let d be the number of completed window lines in the frame. The glyph row is floor(18*d/H) mod 18 and the character-row count is floor(18*d/H) div 18. Both read 0 above the window. Every H window lines therefore yield exactly 18 glyph rows.
- R7: A cell height below 18 behaves exactly as a height of 18.
- R8: Control word 0 is written with the select input at 0, and control word 1 with the select input at 1. The resolution, height and start fields written during a frame do not affect that frame. They take effect at the next vertical edge.
- R9: After reset, and until the first vertical edge, the window is inactive and the dot column, glyph row and character-row outputs are 0. A vertical edge returns the glyph row and the character-row count to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hFlyIn | input | 1 | Horizontal flyback input, programmable polarity |
| vFlyIn | input | 1 | Vertical flyback input, programmable polarity |
| wrEn | input | 1 | Control word write strobe |
| wrSel | input | 1 | Control word select (0 or 1) |
| wrData | input | 16 | Control word write data |
| winActive | output | 1 | OSD window active flag |
| dotCol | output | 11 | Dot column inside the window |
| glyphRow | output | 5 | Glyph row index, 0 to 17 |
| charRow | output | 8 | Character-row count within the frame |

## Verification
Each result is due two clock edges after the flyback edge is sampled, because the synchronizer and the edge register sit in front of the counters. The bench drives one sync slot per clock on the falling edge and samples the outputs on that same falling edge before it drives the next slot. It therefore expects the state belonging to the slot three positions earlier, and it skips the first three slots of each frame, where the outputs still describe the previous frame. Glyph rows and character rows change at the same edge that restarts the dot count, so the closed form floor(18*d/H) applies from the fourth slot of every line. Configuration written in the middle of a frame is expected only after the following frame's vertical edge has been taken.

// File: rtl/osd_win_pkg.sv
package osd_win_pkg;
  localparam int CELL_ROWS  = 18;
  localparam int HPOS_SCALE = 6;
  localparam int VPOS_SCALE = 4;

  typedef struct packed {
    logic hEdge;
    logic vEdge;
  } syncStrobe_t;

  typedef struct packed {
    logic [1:0] resSel;
    logic [5:0] cellHeight;
    logic [7:0] vStart;
    logic [7:0] hStart;
  } winCfg_t;

  localparam winCfg_t CFG_RESET = '{resSel: 2'd0, cellHeight: 6'(CELL_ROWS),
                                    vStart: 8'd0, hStart: 8'd0};
endpackage

// File: rtl/osd_win_ctrl.sv
module osd_win_ctrl
  import osd_win_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hFlyIn,
  input  logic        vFlyIn,
  input  logic        wrEn,
  input  logic        wrSel,
  input  logic [15:0] wrData,
  output syncStrobe_t strobe,
  output winCfg_t     cfg
);
  logic [1:0] polReg;   // [1] horizontal, [0] vertical
  winCfg_t    pendCfg;
  logic [5:0] heightIn;
  logic [1:0] flyRaw, flyPol, flyEdge;

  assign heightIn = wrData[5:0];
  assign flyRaw   = {vFlyIn, hFlyIn};
  assign flyPol   = {polReg[0], polReg[1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      polReg  <= 2'b11;
      pendCfg <= CFG_RESET;
    end else if (wrEn) begin
      if (!wrSel) begin
        polReg             <= wrData[15:14];
        pendCfg.resSel     <= wrData[9:8];
        pendCfg.cellHeight <= (heightIn < 6'(CELL_ROWS)) ? 6'(CELL_ROWS) : heightIn;
      end else begin
        pendCfg.vStart <= wrData[15:8];
        pendCfg.hStart <= wrData[7:0];
      end
    end
  end

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    logic [SYNC_STAGES-1:0] syncQ;
    logic normLvl, prevLvl;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        syncQ   <= '0;
        prevLvl <= 1'b0;
      end else begin
        syncQ   <= {syncQ[SYNC_STAGES-2:0], flyRaw[ch]};
        prevLvl <= normLvl;
      end
    end

    assign normLvl     = flyPol[ch] ? syncQ[SYNC_STAGES-1] : ~syncQ[SYNC_STAGES-1];
    assign flyEdge[ch] = normLvl & ~prevLvl;
  end

  assign strobe.hEdge = flyEdge[0];
  assign strobe.vEdge = flyEdge[1];

  always_ff @(posedge clk) begin
    if (!rst_n)            cfg <= CFG_RESET;
    else if (strobe.vEdge) cfg <= pendCfg;
  end

  // R2
  edge_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.hEdge |=> !strobe.hEdge);

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.vEdge |=> $stable(cfg));

  // R7
  height_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.cellHeight >= 6'(CELL_ROWS));
endmodule

// File: rtl/osd_win_dp.sv
module osd_win_dp
  import osd_win_pkg::*;
#(
  parameter int DOT_W  = 11,
  parameter int LINE_W = 11,
  parameter int CHAR_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  syncStrobe_t                  strobe,
  input  winCfg_t                      cfg,
  output logic                         winActive,
  output logic [DOT_W-1:0]             dotCol,
  output logic [$clog2(CELL_ROWS)-1:0] glyphRow,
  output logic [CHAR_W-1:0]            charRow
);
  localparam int GLYPH_W = $clog2(CELL_ROWS);
  localparam int ACC_W   = $clog2(64 + CELL_ROWS);

  logic [DOT_W-1:0]  dotCnt, dotsPerLine;
  logic [LINE_W-1:0] lineCnt;
  logic [DOT_W+1:0]  hOff;
  logic [LINE_W+1:0] vOff;
  logic [ACC_W-1:0]  acc, accNext, heightExt;
  logic              frameSeen, lineShown;

  always_comb begin
    case (cfg.resSel)
      2'd0:    dotsPerLine = DOT_W'(640);
      2'd1:    dotsPerLine = DOT_W'(800);
      2'd2:    dotsPerLine = DOT_W'(1024);
      default: dotsPerLine = DOT_W'(1280);
    endcase
  end

  assign hOff      = (DOT_W+2)'(cfg.hStart) * (DOT_W+2)'(HPOS_SCALE);
  assign vOff      = (LINE_W+2)'(cfg.vStart) * (LINE_W+2)'(VPOS_SCALE);
  assign heightExt = ACC_W'(cfg.cellHeight);
  assign accNext   = acc + ACC_W'(CELL_ROWS);
  assign lineShown = frameSeen && ({2'b00, lineCnt} >= vOff);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dotCnt <= '0; lineCnt <= '0; acc <= '0;
      glyphRow <= '0; charRow <= '0; frameSeen <= 1'b0;
    end else if (strobe.vEdge) begin
      dotCnt <= '0; lineCnt <= '0; acc <= '0;
      glyphRow <= '0; charRow <= '0; frameSeen <= 1'b1;
    end else if (strobe.hEdge) begin
      dotCnt <= '0;
      if (lineCnt != '1) lineCnt <= lineCnt + 1'b1;
      if (lineShown) begin
        if (accNext >= heightExt) begin
          acc <= accNext - heightExt;
          if (glyphRow == GLYPH_W'(CELL_ROWS - 1)) begin
            glyphRow <= '0;
            charRow  <= charRow + 1'b1;
          end else begin
            glyphRow <= glyphRow + 1'b1;
          end
        end else begin
          acc <= accNext;
        end
      end
    end else if (dotCnt != dotsPerLine) begin
      dotCnt <= dotCnt + 1'b1;
    end
  end

  assign winActive = lineShown && ({2'b00, dotCnt} >= hOff) && (dotCnt < dotsPerLine);
  assign dotCol    = winActive ? (dotCnt - hOff[DOT_W-1:0]) : '0;

  // R6
  glyph_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    glyphRow < GLYPH_W'(CELL_ROWS));

  // R6
  glyph_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.hEdge && !strobe.vEdge) |=> $stable(glyphRow));

  // R3
  dot_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dotCnt <= dotsPerLine);

  // R4
  col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (winActive && !strobe.hEdge && !strobe.vEdge) |=>
      (!winActive || dotCol == $past(dotCol) + DOT_W'(1)));

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.vEdge |=> (glyphRow == '0 && charRow == '0));
endmodule

// File: rtl/osd_window_gen.sv
module osd_window_gen
  import osd_win_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DOT_W       = 11,
  parameter int LINE_W      = 11,
  parameter int CHAR_W      = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         hFlyIn,
  input  logic                         vFlyIn,
  input  logic                         wrEn,
  input  logic                         wrSel,
  input  logic [15:0]                  wrData,
  output logic                         winActive,
  output logic [DOT_W-1:0]             dotCol,
  output logic [$clog2(CELL_ROWS)-1:0] glyphRow,
  output logic [CHAR_W-1:0]            charRow
);
  syncStrobe_t strobe;
  winCfg_t     cfg;

  osd_win_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .hFlyIn(hFlyIn), .vFlyIn(vFlyIn),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .strobe(strobe), .cfg(cfg)
  );

  osd_win_dp #(.DOT_W(DOT_W), .LINE_W(LINE_W), .CHAR_W(CHAR_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .cfg(cfg),
    .winActive(winActive), .dotCol(dotCol), .glyphRow(glyphRow), .charRow(charRow)
  );
endmodule

// File: tb/sim_osd_window_gen.sv
module sim_osd_window_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hFlyIn = 1'b0, vFlyIn = 1'b0;
  logic        wrEn = 1'b0, wrSel = 1'b0;
  logic [15:0] wrData = '0;
  logic        winActive;
  logic [10:0] dotCol;
  logic [4:0]  glyphRow;
  logic [7:0]  charRow;

  int checkCnt = 0, failCnt = 0;
  bit done = 1'b0;

  // pending (written) configuration
  int pRes = 0, pH = 18, pV = 0, pHs = 0, pHp = 1, pVp = 1;
  // configuration to write in the middle of a frame
  int nRes = 0, nH = 18, nV = 0, nHs = 0;

  always #2 clk = ~clk;

  osd_window_gen u0 (
    .clk(clk), .rst_n(rst_n), .hFlyIn(hFlyIn), .vFlyIn(vFlyIn),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .winActive(winActive), .dotCol(dotCol), .glyphRow(glyphRow), .charRow(charRow)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checkCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] word0(input int hp, input int vp, input int res, input int h);
    return {hp[0], vp[0], 4'b0, res[1:0], 2'b0, h[5:0]};
  endfunction

  function automatic logic [15:0] word1(input int v, input int hs);
    return {v[7:0], hs[7:0]};
  endfunction

  task automatic writeCfg(input int hp, input int vp, input int res, input int h,
                          input int v, input int hs);
    pHp = hp; pVp = vp; pRes = res; pH = h; pV = v; pHs = hs;
    @(negedge clk);
    wrEn = 1'b1; wrSel = 1'b0; wrData = word0(hp, vp, res, h);
    hFlyIn = !hp[0]; vFlyIn = !vp[0];
    @(negedge clk);
    wrSel = 1'b1; wrData = word1(v, hs);
    @(negedge clk);
    wrEn = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic runFrame(input string tag, input int lineLen, input int nLines, input int midLine);
    int fRes, fH, vOffE, hOffE, dpl, eIdx, el, ep, d, g;
    int expAct, expCol, expGly, expChr;
    fRes = pRes; fH = (pH < 18) ? 18 : pH;
    vOffE = pV * 4; hOffE = pHs * 6;
    dpl = (fRes == 0) ? 640 : (fRes == 1) ? 800 : (fRes == 2) ? 1024 : 1280;
    for (int l = 0; l < nLines; l++) begin
      for (int p = 0; p < lineLen; p++) begin
        @(negedge clk);
        if (!(l == 0 && p < 3)) begin
          eIdx = l * lineLen + p - 3;
          el = eIdx / lineLen;
          ep = eIdx % lineLen;
          expAct = (el >= vOffE && ep >= hOffE && ep < dpl) ? 1 : 0;
          expCol = expAct ? (ep - hOffE) : 0;
          if (el >= vOffE) begin
            d = el - vOffE;
            g = (18 * d) / fH;
            expGly = g % 18;
            expChr = (g / 18) % 256;
          end else begin
            expGly = 0; expChr = 0;
          end
          chk(tag, "winActive", int'(winActive), expAct);
          chk(tag, "dotCol", int'(dotCol), expCol);
          chk(tag, "glyphRow", int'(glyphRow), expGly);
          chk(tag, "charRow", int'(charRow), expChr);
        end
        hFlyIn = (p < 4) ? pHp[0] : !pHp[0];
        vFlyIn = (l < 2) ? pVp[0] : !pVp[0];
        if (l == midLine) begin
          if (p == 5) begin
            wrEn = 1'b1; wrSel = 1'b0; wrData = word0(pHp, pVp, nRes, nH);
          end else if (p == 6) begin
            wrSel = 1'b1; wrData = word1(nV, nHs);
          end else if (p == 7) begin
            wrEn = 1'b0;
            pRes = nRes; pH = nH; pV = nV; pHs = nHs;
          end
        end
      end
    end
    @(negedge clk);
    hFlyIn = !pHp[0]; vFlyIn = !pVp[0];
    repeat (6) @(negedge clk);
  endtask

  initial begin : main
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9", "winActive", int'(winActive), 0);
    chk("R9", "dotCol", int'(dotCol), 0);
    chk("R9", "glyphRow", int'(glyphRow), 0);
    chk("R9", "charRow", int'(charRow), 0);

    writeCfg(1, 1, 0, 18, 2, 2);
    // R8: nothing visible before the first vertical edge
    chk("R8", "winActive", int'(winActive), 0);
    runFrame("R2", 48, 90, -1);
    runFrame("R4", 48, 90, -1);
    writeCfg(0, 0, 0, 18, 2, 2);
    runFrame("R1", 48, 90, -1);
    writeCfg(1, 0, 0, 18, 2, 2);
    runFrame("R1", 48, 90, -1);
    writeCfg(0, 1, 0, 36, 1, 1);
    runFrame("R6", 48, 90, -1);
    writeCfg(1, 1, 0, 25, 1, 3);
    runFrame("R6", 48, 90, -1);
    writeCfg(1, 1, 0, 63, 0, 0);
    runFrame("R6", 48, 90, -1);
    writeCfg(1, 1, 0, 5, 1, 2);
    runFrame("R7", 48, 90, -1);
    writeCfg(1, 1, 0, 17, 2, 1);
    nRes = 0; nH = 45; nV = 3; nHs = 4;
    runFrame("R8", 48, 90, 40);
    runFrame("R8", 48, 90, -1);
    writeCfg(1, 1, 0, 19, 20, 5);
    runFrame("R5", 48, 90, -1);
    for (int r = 0; r < 4; r++) begin
      writeCfg(1, 1, r, 18, 0, 10);
      runFrame("R3", 1300, 3, -1);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog run did not complete actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end
endmodule